// File: doc/BRIEF.md
# Windowed Syndrome Decode Scheduler

This block sits between the readout path of an error-corrected quantum processor and a decoder backend. Each error-correction round delivers one syndrome packet, one bit per stabilizer, so a distance-d patch produces d²−1 bits (8 bits at distance 3). The packets collect in a decode queue. The scheduler hands them to the backend as overlapping windows of consecutive rounds over a valid/ready request channel, and the backend answers with a single response pulse. Each window commits only its older rounds. The newer rounds stay queued and form the front of the next window, so every window does a bounded amount of work and every round is seen twice at the seam.

The scheduler allows one window in flight. It times each window against a deadline and flags responses that come back late. It also watches the queue depth: when the backend falls behind the round cadence, the occupancy stays high and the scheduler raises a backlog alarm. When the logical scheduler gives advance notice of a feed-forward barrier, the block stops waiting for full windows. It sends whatever is queued as back-to-back partial windows and pulses a completion flag once the queue is empty and no window is outstanding.

Top module: `sds_top`

## Requirements
- R1: After reset, syn_ready is 1 and req_valid, drain_done, rsp_late, backlog_alarm and overflow_err are all 0.
- R2: While fewer than DEPTH packets are queued, syn_ready is 1, and packets leave the queue in arrival order.
- R3: With DEPTH packets queued, syn_ready is 0. A syn_valid in that state sets overflow_err, which stays 1 until reset. No queued packet is lost or overwritten.
- R4: With no window outstanding and at least WIN_LEN packets queued, req_valid is 1 and req_count is WIN_LEN. req_window lane i, at bits [i*SYN_W +: SYN_W], holds the i-th oldest queued packet. req_valid stays 1 until req_ready is seen.
- R5: A full window retires only its COMMIT oldest packets when it is accepted, so the next window begins with the packet at position COMMIT of the previous one.
- R6: After a window is accepted, req_valid stays 0 until rsp_valid is seen.
- R7: A response sampled more than LATE_LIMIT clock cycles after the accepting edge produces a one-cycle rsp_late pulse on the following cycle. A response sampled at LATE_LIMIT cycles or earlier produces none.
- R8: backlog_alarm is 1 while, for at least cfg_backlog_rounds consecutive accepted packets, the occupancy before each arrival exceeded cfg_backlog_thresh. It drops as soon as the occupancy no longer exceeds the threshold. A value of 0 in cfg_backlog_rounds disables the alarm.
- R9: After barrier_notice, windows of fewer than WIN_LEN packets are also dispatched. In that case req_count equals the number queued, unused lanes read 0, and up to COMMIT packets are retired per window until the queue is empty.
- R10: While a barrier drain is pending, drain_done pulses for one cycle once the queue is empty and no window is outstanding. A notice given with an empty, idle queue completes one cycle after it is registered.
- R11: Without a pending barrier, fewer than WIN_LEN queued packets never raise req_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| syn_valid | input | 1 | Syndrome packet present |
| syn_data | input | SYN_W | Syndrome packet, one bit per stabilizer |
| syn_ready | output | 1 | Queue can take a packet |
| cfg_backlog_thresh | input | CNT_W | Occupancy above which a round counts toward the alarm |
| cfg_backlog_rounds | input | PERSIST_W | Consecutive high-occupancy rounds needed to raise the alarm (0 disables it) |
| barrier_notice | input | 1 | Advance notice of a feed-forward barrier; starts a drain |
| req_valid | output | 1 | Window request to the decoder |
| req_ready | input | 1 | Decoder accepts the window |
| req_window | output | WIN_LEN*SYN_W | Window packets, lane 0 oldest |
| req_count | output | RC_W | Number of valid lanes in the window |
| rsp_valid | input | 1 | Decoder finished the outstanding window |
| rsp_late | output | 1 | Pulse: the last response missed its deadline |
| drain_done | output | 1 | Pulse: barrier drain complete |
| backlog_alarm | output | 1 | Processing is falling behind arrivals |
| overflow_err | output | 1 | Sticky: a packet was offered while the queue was full |

## Verification
The tests queue a run of distinct packet values and compare the lanes of two successive full windows. This shows whether the commit step retires the right number of rounds and keeps the overlap. A queue of three packets, first without and then with a barrier notice, shows whether partial windows are held back or sent, and whether unused lanes are zero-filled. Responses at exactly the deadline and one cycle past it locate the lateness boundary. A queue filled to its limit and then offered one more packet shows whether the head survives the refused write. A slow-drain pattern around the programmed threshold shows whether the alarm counts consecutive rounds and whether it clears when the occupancy drops.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [1:0] {
        DISP_HOLD,
        DISP_FULL,
        DISP_DRAIN
    } disp_mode_e;

    function automatic int unsigned umin(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/sds_queue.sv
module sds_queue #(
    parameter int SYN_W   = 8,
    parameter int DEPTH   = 16,
    parameter int WIN_LEN = 4,
    parameter int CNT_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [SYN_W-1:0]         push_data,
    input  logic [CNT_W-1:0]         pop_n,
    output logic [CNT_W-1:0]         count,
    output logic [WIN_LEN*SYN_W-1:0] win_data
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SYN_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            rd_ptr <= rd_ptr + pop_n[PTR_W-1:0];
            count  <= count + CNT_W'(push) - pop_n;
        end
    end

    for (genvar i = 0; i < WIN_LEN; i++) begin : g_lane
        logic [PTR_W-1:0] idx;
        assign idx = rd_ptr + PTR_W'(i);
        assign win_data[i*SYN_W +: SYN_W] = (CNT_W'(i) < count) ? mem[idx] : '0;
    end

endmodule

// File: rtl/sds_backlog.sv
module sds_backlog #(
    parameter int CNT_W     = 5,
    parameter int PERSIST_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 arrive,
    input  logic [CNT_W-1:0]     count,
    input  logic [CNT_W-1:0]     thresh,
    input  logic [PERSIST_W-1:0] rounds,
    output logic                 alarm
);
    logic [PERSIST_W-1:0] streak;
    logic                 over;

    assign over = count > thresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            streak <= '0;
        end else if (!over) begin
            streak <= '0;
        end else if (arrive && streak != '1) begin
            streak <= streak + 1'b1;
        end
    end

    assign alarm = (rounds != '0) && (streak >= rounds);

endmodule

// File: rtl/sds_dispatch.sv
module sds_dispatch
    import sds_pkg::*;
#(
    parameter int WIN_LEN    = 4,
    parameter int COMMIT     = 2,
    parameter int CNT_W      = 5,
    parameter int RC_W       = 3,
    parameter int LATE_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             barrier_notice,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output logic             req_valid,
    output logic [RC_W-1:0]  req_count,
    output logic [CNT_W-1:0] pop_n,
    output logic             rsp_late,
    output logic             drain_done
);
    localparam int TMR_W = $clog2(LATE_LIMIT + 1);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN_LEN);
    localparam logic [CNT_W-1:0] COM_C = CNT_W'(COMMIT);

    disp_mode_e       mode;
    logic             busy;
    logic [TMR_W-1:0] timer;
    logic             drain_pending;
    logic             fire;
    logic             done_cond;

    always_comb begin
        if (busy)                             mode = DISP_HOLD;
        else if (count >= WIN_C)              mode = DISP_FULL;
        else if (drain_pending && count != 0) mode = DISP_DRAIN;
        else                                  mode = DISP_HOLD;
    end

    assign req_valid = (mode != DISP_HOLD);
    assign req_count = (count >= WIN_C) ? RC_W'(WIN_LEN) : RC_W'(count);
    assign fire      = req_valid && req_ready;

    always_comb begin
        pop_n = '0;
        if (fire) pop_n = (mode == DISP_FULL) ? COM_C : CNT_W'(umin(count, COMMIT));
    end

    assign done_cond = drain_pending && (count == 0) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            timer         <= '0;
            rsp_late      <= 1'b0;
            drain_pending <= 1'b0;
            drain_done    <= 1'b0;
        end else begin
            rsp_late <= rsp_valid && busy && (timer >= TMR_W'(LATE_LIMIT));
            if (fire) begin
                busy  <= 1'b1;
                timer <= '0;
            end else if (busy) begin
                if (rsp_valid) busy <= 1'b0;
                if (timer != TMR_W'(LATE_LIMIT)) timer <= timer + 1'b1;
            end
            drain_pending <= barrier_notice || (drain_pending && !done_cond);
            drain_done    <= done_cond;
        end
    end

endmodule

// File: rtl/sds_top.sv
module sds_top
    import sds_pkg::*;
#(
    parameter int DISTANCE   = 3,
    parameter int DEPTH      = 16,
    parameter int WIN_LEN    = 4,
    parameter int COMMIT     = 2,
    parameter int PERSIST_W  = 8,
    parameter int LATE_LIMIT = 16,
    localparam int SYN_W     = DISTANCE * DISTANCE - 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int RC_W      = $clog2(WIN_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     syn_valid,
    input  logic [SYN_W-1:0]         syn_data,
    output logic                     syn_ready,
    input  logic [CNT_W-1:0]         cfg_backlog_thresh,
    input  logic [PERSIST_W-1:0]     cfg_backlog_rounds,
    input  logic                     barrier_notice,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [WIN_LEN*SYN_W-1:0] req_window,
    output logic [RC_W-1:0]          req_count,
    input  logic                     rsp_valid,
    output logic                     rsp_late,
    output logic                     drain_done,
    output logic                     backlog_alarm,
    output logic                     overflow_err
);
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] pop_n;
    logic             push;

    assign syn_ready = count < CNT_W'(DEPTH);
    assign push      = syn_valid && syn_ready;

    always_ff @(posedge clk) begin
        if (rst) overflow_err <= 1'b0;
        else if (syn_valid && !syn_ready) overflow_err <= 1'b1;
    end

    sds_queue #(.SYN_W(SYN_W), .DEPTH(DEPTH), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_queue (
        .clk(clk), .rst(rst), .push(push), .push_data(syn_data),
        .pop_n(pop_n), .count(count), .win_data(req_window)
    );

    sds_backlog #(.CNT_W(CNT_W), .PERSIST_W(PERSIST_W)) u_backlog (
        .clk(clk), .rst(rst), .arrive(push), .count(count),
        .thresh(cfg_backlog_thresh), .rounds(cfg_backlog_rounds), .alarm(backlog_alarm)
    );

    sds_dispatch #(.WIN_LEN(WIN_LEN), .COMMIT(COMMIT), .CNT_W(CNT_W), .RC_W(RC_W),
                   .LATE_LIMIT(LATE_LIMIT)) u_dispatch (
        .clk(clk), .rst(rst), .count(count), .barrier_notice(barrier_notice),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .req_valid(req_valid),
        .req_count(req_count), .pop_n(pop_n), .rsp_late(rsp_late), .drain_done(drain_done)
    );

endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
    parameter int WIN_LEN = 4,
    parameter int RC_W    = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            syn_valid,
    input logic            syn_ready,
    input logic            req_valid,
    input logic            req_ready,
    input logic [RC_W-1:0] req_count,
    input logic            rsp_valid,
    input logic            rsp_late,
    input logic            drain_done,
    input logic            overflow_err
);
    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    assert_full_offer_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (syn_valid && !syn_ready) |=> overflow_err);

    assert_req_held_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid);

    assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid);

    assert_late_needs_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_late |-> $past(rsp_valid));

    assert_window_size_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_count != 0 && req_count <= RC_W'(WIN_LEN)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        drain_done |=> !drain_done);

endmodule

bind sds_top sds_checker #(.WIN_LEN(WIN_LEN), .RC_W(RC_W)) u_chk (
    .clk(clk), .rst(rst), .syn_valid(syn_valid), .syn_ready(syn_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_count(req_count),
    .rsp_valid(rsp_valid), .rsp_late(rsp_late), .drain_done(drain_done),
    .overflow_err(overflow_err)
);

// File: tb/sim_sds_top.sv
`timescale 1ns/1ps
module sim_sds_top;
    localparam int W = 8, WL = 4, CW = 5, RCW = 3, PW = 8, LIM = 16;

    logic clk = 1'b0;
    logic rst;
    logic syn_valid = 1'b0;
    logic [W-1:0] syn_data = '0;
    logic syn_ready;
    logic [CW-1:0] cfg_thresh = 5'd15;
    logic [PW-1:0] cfg_rounds = '0;
    logic barrier_notice = 1'b0;
    logic req_valid, req_ready = 1'b0;
    logic [WL*W-1:0] req_window;
    logic [RCW-1:0] req_count;
    logic rsp_valid = 1'b0;
    logic rsp_late, drain_done, backlog_alarm, overflow_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sds_top u0 (
        .clk(clk), .rst(rst), .syn_valid(syn_valid), .syn_data(syn_data), .syn_ready(syn_ready),
        .cfg_backlog_thresh(cfg_thresh), .cfg_backlog_rounds(cfg_rounds),
        .barrier_notice(barrier_notice), .req_valid(req_valid), .req_ready(req_ready),
        .req_window(req_window), .req_count(req_count), .rsp_valid(rsp_valid),
        .rsp_late(rsp_late), .drain_done(drain_done), .backlog_alarm(backlog_alarm),
        .overflow_err(overflow_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; syn_valid = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
        barrier_notice = 1'b0; cfg_thresh = 5'd15; cfg_rounds = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] v);
        @(negedge clk); syn_valid = 1'b1; syn_data = v;
        @(negedge clk); syn_valid = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    // response sampled k edges after the accepting edge; ends at negedge after it
    task automatic respond(input int k);
        repeat (k - 1) @(negedge clk);
        rsp_valid = 1'b1;
        @(negedge clk); rsp_valid = 1'b0;
    endtask

    task automatic barrier();
        @(negedge clk); barrier_notice = 1'b1;
        @(negedge clk); barrier_notice = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check("R1 syn_ready", syn_ready, 1);
        check("R1 req_valid", req_valid, 0);
        check("R1 flags", {drain_done, rsp_late, backlog_alarm, overflow_err}, 0);
    endtask

    task automatic t_window();
        do_reset();
        for (int i = 0; i < 6; i++) push(W'(8'h10 + i));
        check("R2 syn_ready", syn_ready, 1);
        check("R4 req_valid", req_valid, 1);
        check("R4 req_count", req_count, 4);
        check("R4 window lanes", req_window, 32'h13121110);
        accept();
        check("R6 no second request", req_valid, 0);
        respond(3);
        check("R7 on-time no late", rsp_late, 0);
        check("R5 next window valid", req_valid, 1);
        check("R5 overlap lanes", req_window, 32'h15141312);
        accept();
        respond(1);
        check("R11 partial held", req_valid, 0);
    endtask

    task automatic t_late();
        do_reset();
        for (int i = 0; i < 4; i++) push(W'(i));
        accept();
        respond(LIM);
        check("R7 at limit", rsp_late, 0);
        push(8'h04); push(8'h05);
        accept();
        respond(LIM + 1);
        check("R7 past limit", rsp_late, 1);
        @(negedge clk);
        check("R7 pulse ends", rsp_late, 0);
    endtask

    task automatic t_drain();
        do_reset();
        barrier();
        check("R10 empty not yet", drain_done, 0);
        @(negedge clk);
        check("R10 empty done", drain_done, 1);
        @(negedge clk);
        check("R10 pulse", drain_done, 0);
        for (int i = 0; i < 5; i++) push(W'(8'h20 + i));
        accept();
        respond(2);
        check("R11 three held", req_valid, 0);
        barrier();
        check("R9 partial valid", req_valid, 1);
        check("R9 partial count", req_count, 3);
        check("R9 partial lanes", req_window, 32'h00242322);
        accept();
        respond(1);
        check("R9 back to back", req_valid, 1);
        check("R9 last count", req_count, 1);
        check("R9 last lanes", req_window, 32'h00000024);
        accept();
        check("R10 not while busy", drain_done, 0);
        respond(1);
        check("R10 not same cycle", drain_done, 0);
        @(negedge clk);
        check("R10 drain done", drain_done, 1);
        check("R9 queue empty", req_valid, 0);
    endtask

    task automatic t_backlog();
        do_reset();
        cfg_thresh = 5'd2; cfg_rounds = 8'd3;
        for (int i = 0; i < 5; i++) push(W'(i));
        check("R8 two rounds high", backlog_alarm, 0);
        push(8'h05);
        check("R8 three rounds high", backlog_alarm, 1);
        @(negedge clk); cfg_thresh = 5'd6;
        @(negedge clk);
        check("R8 clears below threshold", backlog_alarm, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        for (int i = 0; i < 15; i++) push(W'(8'h30 + i));
        check("R2 ready below full", syn_ready, 1);
        push(8'h3f);
        check("R3 ready low when full", syn_ready, 0);
        check("R3 no error yet", overflow_err, 0);
        push(8'hff);
        check("R3 error set", overflow_err, 1);
        @(negedge clk);
        check("R3 error sticky", overflow_err, 1);
        check("R3 head intact", req_window, 32'h33323130);
        accept();
        respond(1);
        check("R2 order kept", req_window, 32'h35343332);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        t_reset();
        t_window();
        t_late();
        t_drain();
        t_backlog();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule